// File: doc/BRIEF.md
# I2C Target Front End with High-Speed Entry

This block is the serial front end of a bus target. A fast system clock oversamples the two bus lines. The block finds the bus conditions, takes in the address byte and answers a byte that selects it. The address byte carries a fixed four-bit device code and a three-bit address, which is set on a configuration input. The block does not answer a high-speed master code, but it notes it with a mode flag. Only the next STOP clears that flag.

On a write the block passes each received byte to the register side as a one-cycle strobe. A flag marks the byte that follows the address. On a read it asks the register side for each byte with a one-cycle request. It sends that byte MSB first and keeps going while the master acknowledges. It stops sending when the master leaves the acknowledge bit high. SDA is driven only as an open-drain enable.

Top module: `i2c_target_hs`

## Requirements
- R1: A START (SDA falls while SCL is high) and a STOP (SDA rises while SCL is high) are detected after two-flop synchronisation. Out of reset and after a STOP, sda_oe_o is 0, hs_mode_o is 0 and rx_valid_o is 0.
- R2: The first byte after a START is an address byte, taken MSB first on SCL rising edges. Bits 7..4 must equal 4'b1100, bits 3..1 must equal dev_addr_i, and bit 0 is R/W (1 = read). On a match, sda_oe_o is 1 throughout the high phase of the ninth SCL pulse.
- R3: On an address mismatch the block does not drive SDA until the next START, including during later acknowledge slots, and it emits no rx_valid_o.
- R4: An address-position byte whose bits 7..3 equal 5'b00001 is not acknowledged, and it sets hs_mode_o.
- R5: hs_mode_o stays set through repeated STARTs and later transfers, and the next STOP clears it.
- R6: On a write (R/W = 0), each later byte is acknowledged and raises rx_valid_o for one cycle, with rx_data_o holding the byte (MSB first on the bus). rx_first_o is 1 only for the first byte after the address.
- R7: On a read (R/W = 1), tx_req_o pulses once per byte and tx_data_i is sampled in that cycle. The bits go out MSB first, with sda_oe_o = 1 for a 0 bit.
- R8: The read goes on after a master ACK (SDA low in the ninth pulse). After a NACK, no further tx_req_o is issued and SDA stays released until the next START.
- R9: A repeated START at any bit position abandons the current byte and restarts address reception. The next write byte is flagged with rx_first_o.
- R10: During the master's acknowledge slot of a read, sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr_i | input | 3 | Configurable address bits of this target |
| tx_data_i | input | 8 | Read byte, sampled while tx_req_o is 1 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| hs_mode_o | output | 1 | High-speed mode indication |
| rx_valid_o | output | 1 | One-cycle strobe for a received write byte |
| rx_data_o | output | 8 | Received write byte |
| rx_first_o | output | 1 | With rx_valid_o: byte directly follows the address |
| tx_req_o | output | 1 | One-cycle request for the next read byte |

## Verification
A bus condition and the end-of-byte decision can both be pending in the same cycle. Two cases show this: a repeated START arriving while a byte is half shifted, and a STOP arriving while the high-speed flag is set. The bench inserts a repeated START after every bit count from one to seven. It then checks that the following address is acknowledged and that the next data byte carries the first-byte flag. For each of the eight high-speed code variants, it checks that the flag survives a repeated START and an acknowledged address, and that it drops once the STOP is seen.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [3:0] DEV_CODE  = 4'b1100;
  localparam logic [4:0] HS_PREFIX = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions need SCL high in both samples
  assign start_o    = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign scl_rise_o = ~scl_q & scl_s_i;
  assign scl_fall_o = scl_q & ~scl_s_i;
endmodule

// File: rtl/i2c_target_hs.sv
module i2c_target_hs
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              hs_mode_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_first_o,
  output logic              tx_req_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [1:0] raw_w, syn_w;
  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_w[g]),
      .q_o    (syn_w[g])
    );
  end

  logic start_w, stop_w, rise_w, fall_w;

  i2c_tgt_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (syn_w[1]),
    .sda_s_i    (syn_w[0]),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q, txsh_q, rx_data_q;
  logic              rw_q, first_q, ack_ok_q, hs_q, oe_q, rx_valid_q, rx_first_q;
  logic              tx_req_w;

  assign tx_req_w = !start_w && !stop_w && fall_w &&
                    ((state_q == ST_ADDR_ACK && rw_q) || (state_q == ST_RD_ACK && ack_ok_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      txsh_q     <= '0;
      rx_data_q  <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      ack_ok_q   <= 1'b0;
      hs_q       <= 1'b0;
      oe_q       <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_first_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (start_w) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_w) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        hs_q    <= 1'b0;
      end else if (tx_req_w) begin
        oe_q    <= ~tx_data_i[BYTE_W-1];
        txsh_q  <= {tx_data_i[BYTE_W-2:0], 1'b0};
        cnt_q   <= CNT_W'(1);
        state_q <= ST_RD;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (rise_w && cnt_q != LAST_BIT) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], syn_w[0]};
              cnt_q   <= cnt_q + 1'b1;
            end else if (fall_w && cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shreg_q[7:3] == HS_PREFIX) begin
                  hs_q    <= 1'b1;
                  state_q <= ST_IDLE;
                end else if (shreg_q[7:1] == {DEV_CODE, dev_addr_i}) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shreg_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= shreg_q;
                rx_first_q <= first_q;
                first_q    <= 1'b0;
                oe_q       <= 1'b1;
                state_q    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (fall_w) begin  // read path handled by tx_req_w
            oe_q    <= 1'b0;
            first_q <= 1'b1;
            state_q <= ST_WR;
          end
          ST_WR_ACK: if (fall_w) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WR;
          end
          ST_RD: if (fall_w) begin
            if (cnt_q == LAST_BIT) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              oe_q   <= ~txsh_q[BYTE_W-1];
              txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
              cnt_q  <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (rise_w) ack_ok_q <= ~syn_w[0];
            else if (fall_w) state_q <= ST_IDLE;  // NACK: wait for START/STOP
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign hs_mode_o  = hs_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign rx_first_o = rx_first_q;
  assign tx_req_o   = tx_req_w;
endmodule

// File: rtl/i2c_target_hs_chk.sv
module i2c_target_hs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic hs_mode_o,
  input logic rx_valid_o,
  input logic tx_req_o,
  input logic start_w,
  input logic stop_w
);
  assert_ack_with_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sda_oe_o);

  assert_rd_wr_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> !rx_valid_o);

  assert_hs_code_noack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> !sda_oe_o);

  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (!hs_mode_o && !sda_oe_o));

  assert_hs_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_o && !stop_w) |=> hs_mode_o);

  assert_start_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);
endmodule

bind i2c_target_hs i2c_target_hs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .hs_mode_o  (hs_mode_o),
  .rx_valid_o (rx_valid_o),
  .tx_req_o   (tx_req_o),
  .start_w    (start_w),
  .stop_w     (stop_w)
);

// File: tb/i2c_target_hs_test.sv
module i2c_target_hs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       scl = 1'b1, m_sda = 1'b1;
  logic [2:0] dev = 3'd0;
  logic [7:0] tx_data;
  logic       sda_oe, hs, rxv, rxf, txr;
  logic [7:0] rxd;
  logic       sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_target_hs uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_addr_i(dev), .tx_data_i(tx_data), .sda_oe_o(sda_oe), .hs_mode_o(hs),
    .rx_valid_o(rxv), .rx_data_o(rxd), .rx_first_o(rxf), .tx_req_o(txr)
  );

  int tests = 0, fails = 0;
  int rx_n = 0, rd_idx = 0;
  logic [7:0] rx_log [64];
  logic       rxf_log [64];

  function automatic logic [7:0] rd_val(int i);
    return 8'(8'h5A + i * 37);
  endfunction
  assign tx_data = rd_val(rd_idx);

  always @(posedge clk) begin
    if (rst_n && rxv) begin
      rx_log[rx_n % 64]  <= rxd;
      rxf_log[rx_n % 64] <= rxf;
      rx_n <= rx_n + 1;
    end
    if (rst_n && txr) rd_idx <= rd_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; w(5); scl = 1'b1; w(10); m_sda = 1'b0; w(10); scl = 1'b0; w(5);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; w(5); scl = 1'b1; w(10); m_sda = 1'b1; w(10);
  endtask

  task automatic clk_bit(input logic b, output logic oe_mid);
    m_sda = b; w(5); scl = 1'b1; w(5); oe_mid = sda_oe; w(5); scl = 1'b0; w(5);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic o;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], o);
    clk_bit(1'b1, ack);
  endtask

  task automatic rd_byte(input bit m_ack, output logic [7:0] d, output logic oe_ack);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, o);
      d[i] = ~o;
    end
    clk_bit(m_ack ? 1'b0 : 1'b1, oe_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack, o;
    logic [7:0] d;
    int n0, r0;
    w(4); rst_n = 1'b1; w(4);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    chk(hs == 1'b0, "R1 reset hs", hs, 0);
    chk(rxv == 1'b0, "R1 reset rxv", rxv, 0);

    // R2/R3 sweep of configured address vs sent address
    for (int dv = 0; dv < 8; dv++) begin
      dev = 3'(dv);
      for (int a = 0; a < 8; a++) begin
        n0 = rx_n;
        m_start();
        wr_byte({4'hC, 3'(a), 1'b0}, ack);
        chk(ack == (a == dv), "R2 address ack", ack, (a == dv));
        if (a != dv) begin
          wr_byte(8'h00, ack);
          chk(!ack && rx_n == n0, "R3 mismatch silent", ack, 0);
        end
        m_stop();
        chk(!sda_oe, "R1 stop releases", sda_oe, 0);
      end
    end

    // R2 wrong device code
    dev = 3'd5;
    for (int nb = 1; nb < 16; nb++) begin
      if (nb == 12) continue;
      m_start();
      wr_byte({4'(nb), 3'd5, 1'b0}, ack);
      chk(!ack && !hs, "R2 wrong code", ack, 0);
      m_stop();
    end

    // R4/R5 high-speed code variants
    for (int x = 0; x < 8; x++) begin
      m_start();
      wr_byte({5'b00001, 3'(x)}, ack);
      chk(!ack, "R4 hs code not acked", ack, 0);
      chk(hs, "R4 hs set", hs, 1);
      m_start();
      wr_byte({4'hC, 3'd5, 1'b0}, ack);
      chk(ack && hs, "R5 hs held over repeated start", {ack, hs}, 3);
      m_stop();
      w(2);
      chk(!hs, "R5 stop clears hs", hs, 0);
    end

    // R6 write burst
    dev = 3'd3;
    n0 = rx_n;
    m_start();
    wr_byte({4'hC, 3'd3, 1'b0}, ack);
    chk(ack, "R2 write addr", ack, 1);
    for (int k = 0; k < 4; k++) begin
      wr_byte(8'(k * 53 + 17), ack);
      chk(ack, "R6 data ack", ack, 1);
    end
    m_stop();
    chk(rx_n == n0 + 4, "R6 byte count", rx_n - n0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(rx_log[(n0 + k) % 64] == 8'(k * 53 + 17), "R6 data", rx_log[(n0 + k) % 64], 8'(k * 53 + 17));
      chk(rxf_log[(n0 + k) % 64] == (k == 0), "R6 first flag", rxf_log[(n0 + k) % 64], (k == 0));
    end

    // R7/R8/R10 read burst
    r0 = rd_idx;
    m_start();
    wr_byte({4'hC, 3'd3, 1'b1}, ack);
    chk(ack, "R2 read addr", ack, 1);
    for (int k = 0; k < 4; k++) begin
      rd_byte(k < 3, d, o);
      chk(d == rd_val(r0 + k), "R7 read data", d, rd_val(r0 + k));
      chk(!o, "R10 master ack slot released", o, 0);
    end
    for (int k = 0; k < 9; k++) begin
      clk_bit(1'b1, o);
      chk(!o, "R8 released after nack", o, 1'b0);
    end
    chk(rd_idx == r0 + 4, "R8 request count", rd_idx - r0, 4);
    m_stop();

    // R9 repeated start at each bit position
    for (int nbit = 1; nbit < 8; nbit++) begin
      n0 = rx_n;
      m_start();
      wr_byte({4'hC, 3'd3, 1'b0}, ack);
      for (int i = 0; i < nbit; i++) clk_bit(1'b1, o);
      m_start();
      wr_byte({4'hC, 3'd3, 1'b0}, ack);
      chk(ack, "R9 address after restart", ack, 1);
      wr_byte(8'(nbit * 29), ack);
      m_stop();
      chk(rx_n == n0 + 1 && rx_log[n0 % 64] == 8'(nbit * 29) && rxf_log[n0 % 64],
          "R9 restart first byte", rx_log[n0 % 64], 8'(nbit * 29));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule